// File: doc/BRIEF.md
# Programmable-Delay Enable Sequencer

The block drives the on/off controls of several downstream converters. Each channel watches one enable input. When that input goes high, the channel counts millisecond ticks, and after a delay chosen for that channel it raises its `good` output. If the enable falls at any point, `good` drops at once and the count is cleared. Each channel picks its delay from four values. A host loads all the selects together in a single configuration write.

The channels can share one trigger, such as a power-good indication, so that they run in parallel. They can also be chained outside the block, with each channel's enable taken from the `good` output of the channel before it, so that the supplies come up one after another. All channels use one shared prescaler that turns the core clock into a 1 ms tick. The length of that tick in clock cycles is a parameter, so a simulation can use a short one.

Top module: `stage_enable_sequencer`

## Requirements
- R1: After reset every `chGood` bit is low and every channel's select is 2'b00, so a channel enabled with no configuration write uses the shortest delay.
- R2: A channel's `chGood` rises only after its enable has been high for the selected number of ticks. It is low at (D-1)·T cycles after the enable is driven and high at D·T+1 cycles, where T is `TICK_CYCLES` and D is the selected delay in ticks.
- R3: Select encoding: 2'b00 gives `DLY_SEL0` ticks (default 100), 2'b01 gives `DLY_SEL1` (500), 2'b10 gives `DLY_SEL2` (1000) and 2'b11 gives `DLY_SEL3` (5000).
- R4: Channels run independently. Each uses its own select and its own enable, and a channel whose enable is low keeps `chGood` low.
- R5: When `cfgWe` is high, `cfgData[2i+1:2i]` is loaded as the select of channel i, and all channels are loaded in that same cycle.
- R6: When a channel's enable is sampled low, its `chGood` is low after that clock edge. Its count restarts from zero when the enable next goes high.
- R7: A select written while a channel is enabled has no effect on the count in progress. It takes effect at the channel's next enable.
- R8: The shared prescaler gives one tick every `TICK_CYCLES` clock cycles, and all delays are counted in these ticks.
- R9: Once `chGood` is high it stays high for as long as the channel's enable stays high.
- R10: In a chain where enable i+1 is driven by `chGood[i]`, channel n rises about (n+1)·D ticks after channel 0's enable, and dropping channel 0's enable clears the whole chain one channel per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Load strobe for all delay selects |
| cfgData | input | 2*NUM_CH | Packed selects, two bits per channel, channel 0 in the lowest bits |
| chEnable | input | NUM_CH | Per-channel enable (trigger) inputs |
| chGood | output | NUM_CH | Per-channel delayed good outputs |

## Verification
The hardest case to reach from the ports is a select change that lands while a count is already running. The bench writes a shorter select for that channel a few cycles after its enable goes high. It then checks that the rise still follows the old, longer window, and that only the next enable uses the short one. A restart after a partial count is reached the same way. The enable is dropped halfway through a long delay and raised again, and the check that `good` is still low just before the full window, counted from the second rise, shows the count did not resume where it stopped. The relay case feeds the `good` outputs back into the next channel's enable, so the bench can test the chained timing and the cycle-by-cycle collapse of the chain.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef struct packed {
    logic msTick;   // one-cycle pulse per millisecond
    logic cfgLoad;  // load the delay select register
  } seqStrobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  output seqStrobe_t strobes
);
  localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic tickNow;

  generate
    if (TICK_CYCLES > 1) begin : g_presc
      logic [PW-1:0] prescQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) prescQ <= '0;
        else if (prescQ == PW'(TICK_CYCLES - 1)) prescQ <= '0;
        else prescQ <= prescQ + 1'b1;
      end
      assign tickNow = (prescQ == PW'(TICK_CYCLES - 1));
    end else begin : g_every
      assign tickNow = 1'b1;
    end
  endgenerate

  always_comb begin
    strobes.msTick  = tickNow;
    strobes.cfgLoad = cfgWe;
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned DLY_SEL0 = 100,
  parameter int unsigned DLY_SEL1 = 500,
  parameter int unsigned DLY_SEL2 = 1000,
  parameter int unsigned DLY_SEL3 = 5000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strobes,
  input  logic [2*NUM_CH-1:0]   cfgData,
  input  logic [NUM_CH-1:0]     chEnable,
  output logic [NUM_CH-1:0]     chGood
);
  localparam int unsigned MAX01 = (DLY_SEL0 > DLY_SEL1) ? DLY_SEL0 : DLY_SEL1;
  localparam int unsigned MAX23 = (DLY_SEL2 > DLY_SEL3) ? DLY_SEL2 : DLY_SEL3;
  localparam int unsigned DMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned CW    = $clog2(DMAX + 1);

  logic [NUM_CH-1:0][1:0] cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgReg <= '0;
    else if (strobes.cfgLoad) cfgReg <= cfgData;
  end

  function automatic logic [CW-1:0] lastCount(input logic [1:0] sel);
    case (sel)
      2'b00:   lastCount = CW'(DLY_SEL0 - 1);
      2'b01:   lastCount = CW'(DLY_SEL1 - 1);
      2'b10:   lastCount = CW'(DLY_SEL2 - 1);
      default: lastCount = CW'(DLY_SEL3 - 1);
    endcase
  endfunction

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [CW-1:0] cntQ;
      logic [1:0]    selQ;
      logic [1:0]    selUse;
      logic          activeQ;
      logic          goodQ;

      // a running channel keeps the select it captured at its enable
      assign selUse = activeQ ? selQ : cfgReg[i];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cntQ    <= '0;
          selQ    <= '0;
          activeQ <= 1'b0;
          goodQ   <= 1'b0;
        end else if (!chEnable[i]) begin
          cntQ    <= '0;
          activeQ <= 1'b0;
          goodQ   <= 1'b0;
        end else begin
          activeQ <= 1'b1;
          selQ    <= selUse;
          if (strobes.msTick && !goodQ) begin
            if (cntQ == lastCount(selUse)) goodQ <= 1'b1;
            else cntQ <= cntQ + 1'b1;
          end
        end
      end

      assign chGood[i] = goodQ;
    end
  endgenerate
endmodule

// File: rtl/stage_enable_sequencer.sv
module stage_enable_sequencer
  import seq_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned TICK_CYCLES = 100000,
  parameter int unsigned DLY_SEL0    = 100,
  parameter int unsigned DLY_SEL1    = 500,
  parameter int unsigned DLY_SEL2    = 1000,
  parameter int unsigned DLY_SEL3    = 5000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [2*NUM_CH-1:0] cfgData,
  input  logic [NUM_CH-1:0]   chEnable,
  output logic [NUM_CH-1:0]   chGood
);
  seqStrobe_t strobes;

  seq_ctrl #(.TICK_CYCLES(TICK_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .strobes (strobes)
  );

  seq_datapath #(
    .NUM_CH   (NUM_CH),
    .DLY_SEL0 (DLY_SEL0),
    .DLY_SEL1 (DLY_SEL1),
    .DLY_SEL2 (DLY_SEL2),
    .DLY_SEL3 (DLY_SEL3)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgData  (cfgData),
    .chEnable (chEnable),
    .chGood   (chGood)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned TICK_CYCLES = 100000
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chEnable,
  input logic [NUM_CH-1:0] chGood,
  input logic              msTick
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> chGood == '0);

  // R6
  drop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((~$past(chEnable)) & chGood) == '0);

  // R9
  hold_good_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(chGood) & $past(chEnable) & ~chGood) == '0);

  // R2
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((chGood & ~$past(chGood)) != '0) |-> $past(msTick));

  // R2
  rise_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chGood & ~$past(chGood) & ~$past(chEnable)) == '0);

  generate
    if (TICK_CYCLES > 1) begin : g_tick
      // R8
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
        msTick |=> !msTick);
    end
  endgenerate
endmodule

bind stage_enable_sequencer seq_checker #(
  .NUM_CH      (NUM_CH),
  .TICK_CYCLES (TICK_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .chEnable (chEnable),
  .chGood   (chGood),
  .msTick   (strobes.msTick)
);

// File: tb/stage_enable_sequencer_test.sv
module stage_enable_sequencer_test;
  localparam int NCH = 4;
  localparam int T   = 4;
  localparam int D0  = 5;
  localparam int D1  = 10;
  localparam int D2  = 20;
  localparam int D3  = 40;

  typedef struct {
    int    cyc;
    int    ch;
    bit    val;
    string tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWe = 1'b0;
  logic [2*NCH-1:0] cfgData = '0;
  logic [NCH-1:0]   enTop = '0;
  logic             relay = 1'b0;
  logic [NCH-1:0]   chEnable;
  logic [NCH-1:0]   chGood;

  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  item_t sb[$];

  assign chEnable = relay ? {chGood[NCH-2:0], enTop[0]} : enTop;

  stage_enable_sequencer #(
    .NUM_CH(NCH), .TICK_CYCLES(T),
    .DLY_SEL0(D0), .DLY_SEL1(D1), .DLY_SEL2(D2), .DLY_SEL3(D3)
  ) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .chEnable(chEnable), .chGood(chGood)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare due scoreboard items
  always @(negedge clk) begin
    for (int j = sb.size() - 1; j >= 0; j--) begin
      if (sb[j].cyc == cyc) begin
        total++;
        if (chGood[sb[j].ch] !== sb[j].val) begin
          bad++;
          $display("FAIL %s ch%0d cyc%0d: actual=%b expected=%b",
                   sb[j].tag, sb[j].ch, cyc, chGood[sb[j].ch], sb[j].val);
        end
        sb.delete(j);
      end
    end
  end

  task automatic expectAt(int ch, int at, bit val, string tag);
    item_t it;
    it.cyc = at; it.ch = ch; it.val = val; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic expectWindow(int ch, int k, int d, string tag);
    expectAt(ch, k + (d - 1) * T, 1'b0, tag);
    expectAt(ch, k + d * T + 1, 1'b1, tag);
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(logic [2*NCH-1:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgData = v;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    int dl[NCH];
    dl[0] = D0; dl[1] = D1; dl[2] = D2; dl[3] = D3;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    total++;
    if (chGood !== '0) begin
      bad++;
      $display("FAIL R1 reset: actual=%b expected=0000", chGood);
    end

    // R1 default select, R2 / R8 window in ticks, R4 idle channel stays low
    @(negedge clk); enTop = 4'b0001; k = cyc;
    expectWindow(0, k, D0, "R1 R2 R8");
    expectAt(1, k + D0 * T + 1, 1'b0, "R4");
    waitCyc(D0 * T + 4);
    enTop = '0; k = cyc;
    expectAt(0, k + 1, 1'b0, "R6");
    waitCyc(3);

    // R3 / R5: each channel gets its own code, all enabled together
    writeCfg(8'b11_10_01_00);
    @(negedge clk); enTop = 4'hF; k = cyc;
    for (int i = 0; i < NCH; i++) begin
      expectWindow(i, k, dl[i], "R3 R4 R5");
      expectAt(i, k + D3 * T + 10, 1'b1, "R9");
    end
    waitCyc(D3 * T + 12);
    enTop = '0; k = cyc;
    for (int i = 0; i < NCH; i++) expectAt(i, k + 1, 1'b0, "R6");
    waitCyc(3);

    // R7: mid-count select change ignored, applied at next enable
    @(negedge clk); enTop = 4'b0010; k = cyc;
    expectWindow(1, k, D1, "R7");
    waitCyc(3);
    writeCfg(8'b11_10_00_00);
    waitCyc(D1 * T);
    enTop = '0;
    waitCyc(2);
    @(negedge clk); enTop = 4'b0010; k = cyc;
    expectWindow(1, k, D0, "R7");
    waitCyc(D0 * T + 4);
    enTop = '0;
    waitCyc(3);

    // R6: partial count then restart from zero
    @(negedge clk); enTop = 4'b0100; k = cyc;
    expectAt(2, k + 10 * T, 1'b0, "R6");
    waitCyc(10 * T + 2);
    enTop = '0;
    waitCyc(2);
    @(negedge clk); enTop = 4'b0100; k = cyc;
    expectWindow(2, k, D2, "R6");
    waitCyc(D2 * T + 4);
    enTop = '0;
    waitCyc(3);

    // R10: relay chain
    writeCfg('0);
    relay = 1'b1;
    @(negedge clk); enTop = 4'b0001; k = cyc;
    for (int n = 0; n < NCH; n++) begin
      expectAt(n, k + ((n + 1) * D0 - 1) * T, 1'b0, "R10");
      expectAt(n, k + (n + 1) * D0 * T + 1, 1'b1, "R10");
    end
    waitCyc(NCH * D0 * T + 5);
    enTop = '0; k = cyc;
    expectAt(2, k + 2, 1'b1, "R10");
    expectAt(3, k + 4, 1'b0, "R10");
    waitCyc(8);

    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule